// File: doc/BRIEF.md
# Byte-Loaded Double-Buffered DAC Code Register

This block is the digital front end of a 12-bit digital-to-analog converter that is fed from an 8-bit bus. Two staging registers sit between the bus and the converter code: an 8-bit upper stage for word bits 11..4 and a 4-bit lower stage for bits 3..0. The lower nibble is presented on the top four bus pins, so a host writes a full word in two bus cycles. The first cycle has byte-select high and fills both stages; the second has byte-select low and refreshes only the nibble.

A separate pair of active-low strobes copies both staging registers into the 12-bit code register. That register drives the converter code as one whole word, so a partly written word never reaches the output. A one-cycle pulse marks every change of the code, which lets a downstream analog model time its settling interval.

All strobes and the data bus are asynchronous to the system clock. They pass through a two-flop synchronizer, and the loads then act on every clock in which their condition holds. At the clock-sample level this gives the same behaviour as transparent latches.

Top module: `bytewise_dac_loader`

## Requirements
- R1: While `rst` is high on a clock edge, the staging registers and `dac_code` clear to zero and `code_upd` is 0.
- R2: A sampled cycle with `cs_n`=0, `wr1_n`=0 and `byte_sel`=1 loads `bus[7:0]` into the upper stage (word bits 11..4) and `bus[7:4]` into the lower stage (word bits 3..0).
- R3: A sampled cycle with `cs_n`=0, `wr1_n`=0 and `byte_sel`=0 loads only the lower stage from `bus[7:4]`, and the upper stage holds.
- R4: While `cs_n`=1, `wr1_n` has no effect and both staging registers hold.
- R5: A sampled cycle with `wr2_n`=0 and `xfer_n`=0 copies {upper, lower} into `dac_code`, with bit 11 as MSB. This happens whatever the level of `cs_n`.
- R6: While the transfer condition stays asserted, `dac_code` follows the staging registers on every clock.
- R7: When a write and a transfer fall in the same sampled clock, `dac_code` takes the newly written staging values at that same edge.
- R8: `code_upd` is 1 for exactly the cycle after each edge at which `dac_code` changed value, and 0 otherwise. A transfer of an unchanged value gives no pulse.
- R9: An input change reaches `dac_code` at the third rising clock edge after it is applied: two synchronizer stages, then the register.
- R10: With only one of `wr2_n` and `xfer_n` low, `dac_code` holds.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low, gates the write path only |
| wr1_n | input | 1 | Staging write strobe, active low |
| wr2_n | input | 1 | Transfer strobe half, active low |
| xfer_n | input | 1 | Transfer strobe half, active low |
| byte_sel | input | 1 | 1: load both stages; 0: load lower nibble only |
| bus | input | 8 | Data bus; bits 7..4 also carry the lower nibble |
| dac_code | output | 12 | Converter code, all ones is full scale |
| code_upd | output | 1 | One-cycle pulse after each change of `dac_code` |

## Verification
The staging write and the transfer into the code register can fall in the same sampled clock. The bench provokes this by driving `cs_n`, `wr1_n`, `wr2_n` and `xfer_n` low together, and also by holding the transfer pair low across a series of high and low writes. A behavioural model that passes the inputs through a two-entry queue predicts the code on every clock. Flow-through is judged correct only when the freshly written byte and nibble appear in `dac_code` at the same edge that loads them into staging, with a single `code_upd` pulse.

// File: rtl/bdl_pkg.sv
package bdl_pkg;

    typedef struct packed {
        logic cs_n;
        logic wr1_n;
        logic wr2_n;
        logic xfer_n;
        logic sel_hi;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    localparam ctrl_t CTRL_IDLE = '{cs_n: 1'b1, wr1_n: 1'b1, wr2_n: 1'b1,
                                    xfer_n: 1'b1, sel_hi: 1'b0};

    typedef enum logic [1:0] {
        WK_NONE = 2'd0,
        WK_LOW  = 2'd1,
        WK_BOTH = 2'd2
    } wkind_t;

    function automatic wkind_t write_kind(input ctrl_t c);
        if (c.cs_n || c.wr1_n) return WK_NONE;
        return c.sel_hi ? WK_BOTH : WK_LOW;
    endfunction

    function automatic logic xfer_on(input ctrl_t c);
        return !c.wr2_n && !c.xfer_n;
    endfunction

endpackage

// File: rtl/bdl_sync.sv
module bdl_sync #(
    parameter int           W       = 8,
    parameter int           STAGES  = 2,
    parameter logic [W-1:0] RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stg [STAGES];

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            if (i == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) stg[i] <= RST_VAL;
                    else     stg[i] <= stg[i-1];
                end
            end
        end
    endgenerate

    assign q = stg[STAGES-1];
endmodule

// File: rtl/bdl_stage.sv
module bdl_stage #(
    parameter int HI_W = 8,
    parameter int LO_W = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  bdl_pkg::wkind_t wk,
    input  logic [HI_W-1:0] bus,
    output logic [HI_W-1:0] hi_q,
    output logic [LO_W-1:0] lo_q,
    output logic [HI_W-1:0] hi_nxt,
    output logic [LO_W-1:0] lo_nxt
);
    import bdl_pkg::*;

    always_comb begin
        hi_nxt = hi_q;
        lo_nxt = lo_q;
        if (wk == WK_BOTH) hi_nxt = bus;
        if (wk != WK_NONE) lo_nxt = bus[HI_W-1 -: LO_W];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            hi_q <= '0;
            lo_q <= '0;
        end else begin
            hi_q <= hi_nxt;
            lo_q <= lo_nxt;
        end
    end
endmodule

// File: rtl/bdl_code_reg.sv
module bdl_code_reg #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] din,
    output logic [W-1:0] code,
    output logic         upd
);
    always_ff @(posedge clk) begin
        if (rst) begin
            code <= '0;
            upd  <= 1'b0;
        end else begin
            upd <= load && (din != code);
            if (load) code <= din;
        end
    end
endmodule

// File: rtl/bytewise_dac_loader.sv
module bytewise_dac_loader #(
    parameter int HI_W      = 8,
    parameter int LO_W      = 4,
    parameter int SYNC_STGS = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cs_n,
    input  logic                 wr1_n,
    input  logic                 wr2_n,
    input  logic                 xfer_n,
    input  logic                 byte_sel,
    input  logic [HI_W-1:0]      bus,
    output logic [HI_W+LO_W-1:0] dac_code,
    output logic                 code_upd
);
    import bdl_pkg::*;

    localparam int CODE_W = HI_W + LO_W;
    localparam int IN_W   = CTRL_W + HI_W;
    localparam logic [IN_W-1:0] IN_IDLE = {CTRL_IDLE, {HI_W{1'b0}}};

    ctrl_t            ctrl_raw;
    ctrl_t            ctrl_s;
    logic [HI_W-1:0]  bus_s;
    logic [IN_W-1:0]  in_raw;
    logic [IN_W-1:0]  in_s;
    wkind_t           wk;
    logic             ld_both;
    logic             ld_lo;
    logic             xfer_en;
    logic             cs_sync_n;
    logic [HI_W-1:0]  hi_q;
    logic [LO_W-1:0]  lo_q;
    logic [HI_W-1:0]  hi_nxt;
    logic [LO_W-1:0]  lo_nxt;

    assign ctrl_raw = '{cs_n: cs_n, wr1_n: wr1_n, wr2_n: wr2_n,
                        xfer_n: xfer_n, sel_hi: byte_sel};
    assign in_raw   = {ctrl_raw, bus};

    bdl_sync #(
        .W       (IN_W),
        .STAGES  (SYNC_STGS),
        .RST_VAL (IN_IDLE)
    ) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (in_raw),
        .q   (in_s)
    );

    assign ctrl_s    = ctrl_t'(in_s[IN_W-1 -: CTRL_W]);
    assign bus_s     = in_s[HI_W-1:0];
    assign wk        = write_kind(ctrl_s);
    assign ld_both   = (wk == WK_BOTH);
    assign ld_lo     = (wk == WK_LOW);
    assign xfer_en   = xfer_on(ctrl_s);
    assign cs_sync_n = ctrl_s.cs_n;

    bdl_stage #(
        .HI_W (HI_W),
        .LO_W (LO_W)
    ) u_stage (
        .clk    (clk),
        .rst    (rst),
        .wk     (wk),
        .bus    (bus_s),
        .hi_q   (hi_q),
        .lo_q   (lo_q),
        .hi_nxt (hi_nxt),
        .lo_nxt (lo_nxt)
    );

    bdl_code_reg #(
        .W (CODE_W)
    ) u_code (
        .clk  (clk),
        .rst  (rst),
        .load (xfer_en),
        .din  ({hi_nxt, lo_nxt}),
        .code (dac_code),
        .upd  (code_upd)
    );
endmodule

// File: rtl/bdl_chk.sv
module bdl_chk #(
    parameter int HI_W = 8,
    parameter int LO_W = 4
) (
    input logic                 clk,
    input logic                 rst,
    input logic [HI_W+LO_W-1:0] dac_code,
    input logic                 code_upd,
    input logic [HI_W-1:0]      hi_q,
    input logic [LO_W-1:0]      lo_q,
    input logic                 ld_both,
    input logic                 ld_lo,
    input logic                 xfer_en,
    input logic                 cs_sync_n
);
    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && !code_upd && (hi_q == '0) && (lo_q == '0));

    // R2
    both_nibble_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ld_both) |-> (lo_q == hi_q[HI_W-1 -: LO_W]));

    // R3
    low_keeps_hi_chk: assert property (@(posedge clk) disable iff (rst)
        $past(ld_lo) |-> $stable(hi_q));

    // R4
    cs_gate_chk: assert property (@(posedge clk) disable iff (rst)
        $past(cs_sync_n) |-> ($stable(hi_q) && $stable(lo_q)));

    // R7
    flow_through_chk: assert property (@(posedge clk) disable iff (rst)
        $past(xfer_en) |-> (dac_code == {hi_q, lo_q}));

    // R10
    no_xfer_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !$past(xfer_en) |-> $stable(dac_code));

    // R8
    upd_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        code_upd == (dac_code != $past(dac_code)));
endmodule

bind bytewise_dac_loader bdl_chk #(
    .HI_W (HI_W),
    .LO_W (LO_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .dac_code  (dac_code),
    .code_upd  (code_upd),
    .hi_q      (hi_q),
    .lo_q      (lo_q),
    .ld_both   (ld_both),
    .ld_lo     (ld_lo),
    .xfer_en   (xfer_en),
    .cs_sync_n (cs_sync_n)
);

// File: tb/bytewise_dac_loader_tb.sv
`timescale 1ns/1ps
module bytewise_dac_loader_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1, wr1_n = 1'b1, wr2_n = 1'b1, xfer_n = 1'b1;
    logic        byte_sel = 1'b0;
    logic [7:0]  bus = 8'h00;
    logic [11:0] dac_code;
    logic        code_upd;

    int    total = 0;
    int    bad   = 0;
    bit    done  = 0;
    string cur_req = "R1";

    always #2 clk = ~clk;

    bytewise_dac_loader u_dut (
        .clk(clk), .rst(rst), .cs_n(cs_n), .wr1_n(wr1_n), .wr2_n(wr2_n),
        .xfer_n(xfer_n), .byte_sel(byte_sel), .bus(bus),
        .dac_code(dac_code), .code_upd(code_upd)
    );

    // reference model: {cs_n, wr1_n, wr2_n, xfer_n, sel, bus}
    localparam logic [12:0] IDLE = {5'b11110, 8'h00};
    logic [12:0] pipe[$];
    logic [7:0]  mh;
    logic [3:0]  ml;
    logic [11:0] mc;
    logic        mu;

    always @(posedge clk) begin
        if (rst) begin
            pipe = {IDLE, IDLE};
            mh = 0; ml = 0; mc = 0; mu = 0;
        end else begin
            logic [12:0] s;
            logic [7:0]  nh;
            logic [3:0]  nl;
            pipe.push_back({cs_n, wr1_n, wr2_n, xfer_n, byte_sel, bus});
            s  = pipe.pop_front();
            nh = mh;
            nl = ml;
            if (!s[12] && !s[11]) begin
                if (s[8]) nh = s[7:0];
                nl = s[7:4];
            end
            mh = nh;
            ml = nl;
            if (!s[10] && !s[9]) begin
                mu = ({nh, nl} != mc);
                mc = {nh, nl};
            end else begin
                mu = 1'b0;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            check({cur_req, " code vs model"}, dac_code, mc);
            check({cur_req, " upd vs model"}, code_upd, mu);
        end
    end

    task automatic idle_bus();
        cs_n = 1; wr1_n = 1; wr2_n = 1; xfer_n = 1; byte_sel = 0;
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic bus_write(input logic sel, input logic cs, input logic [7:0] d);
        bus = d; byte_sel = sel; cs_n = cs; wr1_n = 0;
        wait_cyc(1);
        idle_bus();
        wait_cyc(1);
    endtask

    task automatic transfer(input logic w2, input logic xf);
        wr2_n = w2; xfer_n = xf; cs_n = 1;
        wait_cyc(1);
        idle_bus();
        wait_cyc(4);
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            done = 1;
            bad++;
            total++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        wait_cyc(4);
        // R1: reset state
        check("R1 code in reset", dac_code, 12'h000);
        check("R1 upd in reset", code_upd, 0);
        rst = 0;
        wait_cyc(3);
        check("R1 code after reset", dac_code, 12'h000);

        // R2 + R5: byte write then transfer with cs_n high
        cur_req = "R2";
        bus_write(1, 0, 8'hA5);
        transfer(0, 0);
        check("R2 full write", dac_code, 12'hA5A);

        // R3: low nibble only
        cur_req = "R3";
        bus_write(0, 0, 8'h3C);
        transfer(0, 0);
        check("R3 nibble only", dac_code, 12'hA53);

        // R4: cs_n high ignores write 1
        cur_req = "R4";
        bus_write(1, 1, 8'hFF);
        bus_write(0, 1, 8'hFF);
        transfer(0, 0);
        check("R4 cs gating code", dac_code, 12'hA53);
        check("R4 no upd", code_upd, 0);

        // R10: half transfers do nothing
        cur_req = "R10";
        bus_write(1, 0, 8'h12);
        transfer(0, 1);
        check("R10 only wr2", dac_code, 12'hA53);
        transfer(1, 0);
        check("R10 only xfer", dac_code, 12'hA53);
        cur_req = "R5";
        transfer(0, 0);
        check("R5 transfer", dac_code, 12'h121);

        // R8: full scale, zero, repeat transfer
        cur_req = "R8";
        bus_write(1, 0, 8'hFF);
        transfer(0, 0);
        check("R8 full scale", dac_code, 12'hFFF);
        transfer(0, 0);
        check("R8 same value no pulse", code_upd, 0);
        bus_write(1, 0, 8'h00);
        transfer(0, 0);
        check("R8 zero", dac_code, 12'h000);

        // R6: transfer held, code follows writes
        cur_req = "R6";
        wr2_n = 0; xfer_n = 0;
        bus = 8'h9B; byte_sel = 1; cs_n = 0; wr1_n = 0;
        wait_cyc(1);
        cs_n = 1; wr1_n = 1;
        wait_cyc(4);
        check("R6 follow hi", dac_code, 12'h9B9);
        bus = 8'h70; byte_sel = 0; cs_n = 0; wr1_n = 0;
        wait_cyc(1);
        cs_n = 1; wr1_n = 1;
        wait_cyc(4);
        check("R6 follow lo", dac_code, 12'h9B7);
        idle_bus();
        wait_cyc(4);

        // R9 + R7: latency and same-cycle write and transfer
        cur_req = "R9";
        bus = 8'h5A; byte_sel = 1; cs_n = 0; wr1_n = 0; wr2_n = 0; xfer_n = 0;
        wait_cyc(1);
        idle_bus();
        wait_cyc(1);
        check("R9 old after two edges", dac_code, 12'h9B7);
        wait_cyc(1);
        check("R7 new at third edge", dac_code, 12'h5A5);
        check("R8 pulse", code_upd, 1);
        wait_cyc(1);
        check("R8 pulse one cycle", code_upd, 0);

        // R7: low nibble write with transfer in same cycle
        cur_req = "R7";
        bus = 8'hC3; byte_sel = 0; cs_n = 0; wr1_n = 0; wr2_n = 0; xfer_n = 0;
        wait_cyc(1);
        idle_bus();
        wait_cyc(4);
        check("R7 nibble flow", dac_code, 12'h5AC);

        // R1: reset mid-run clears code
        cur_req = "R1";
        rst = 1;
        wait_cyc(2);
        check("R1 re-reset", dac_code, 12'h000);
        rst = 0;
        wait_cyc(3);

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule